// File: doc/BRIEF.md
# Shared Interrupt Line Router

This block steers four shared PCI interrupt request lines onto sixteen legacy interrupt controller inputs. Each request line owns one byte-wide routing register. A value below sixteen picks the controller input that the line drives. A value of sixteen or more cuts the line off from all inputs. Every controller input is the wired-OR of all request lines steered to it, so several devices can share one input.

The routing bytes sit in a small configuration space. Software reaches them through a dword-addressed port with a byte-enable mask, so it can change one route without disturbing the others. Internally the block keeps a line-by-request bit matrix. A level change on one request line updates only its own bit. Any write that touches a routing byte clears the matrix and rebuilds it from the present input levels using the new routes.

Two combinational helpers complete the block. A route query reports whether a chosen request line is enabled and which input it drives. A slot swizzle maps a device's INTx pin to a request line number based on the device's slot.

Top module: `pirq_router`

## Requirements
- R1: After reset every routing byte reads 0x80, so all four request lines are disabled, and all sixteen outputs are low.
- R2: The routing bytes for request lines A, B, C and D sit at byte addresses 0x60, 0x61, 0x62 and 0x63. That is byte lanes 0 to 3 of dword address 0x18. A write changes only the lanes whose byte-enable bit is set. Writes to any other dword change no routing byte, and reads of any other dword return zero.
- R3: A request line whose routing byte is below 16 drives output number equal to that byte. Each output is the OR of every enabled request line routed to it.
- R4: A request line whose routing byte is 16 or more drives no output, whatever its level.
- R5: An output changes exactly one clock after the request-line level change that causes it.
- R6: A write to any routing byte takes effect one clock after its write edge. The matrix is rebuilt from the current levels, so an input the line no longer drives is released.
- R7: When a routing write and a level change meet in the same cycle, the result uses the new routes together with the new levels.
- R8: The route query for line select s (0 = A through 3 = D) returns enabled = 1 and the 5-bit line number when that routing byte is below 16. Otherwise it returns enabled = 0 and 5'b11111, which is -1.
- R9: The swizzle returns request line (intx + slot - 1) mod 4, where slot is devfn[7:3] and intx 0 to 3 means INTA to INTD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_dw_addr_i | input | 6 | Configuration dword address (byte address bits 7:2) |
| cfg_be_i | input | 4 | Byte enables for the write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for cfg_dw_addr_i (combinational) |
| pirq_i | input | 4 | Request line levels, bit 0 = A |
| irq_o | output | 16 | Controller input levels |
| route_sel_i | input | 2 | Request line to query |
| route_en_o | output | 1 | Queried line is enabled |
| route_line_o | output | 5 | Queried output number, or all ones when disabled |
| swz_devfn_i | input | 8 | Device/function number for the swizzle |
| swz_intx_i | input | 2 | INTx pin for the swizzle |
| swz_pirq_o | output | 2 | Swizzled request line |

## Verification
A level change on a request line and a routing write can land on the same clock edge. The two update paths then compete for the same matrix. The bench provokes this in every table vector by driving new routes and new levels in one cycle. It also runs a directed case that moves line A to a new output while A rises and line B falls. The outputs are judged one clock later against the pattern the new routes and new levels imply. No stale bit from the old route or the old level may survive.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;
  localparam int unsigned ROUTE_W = 8;
  typedef logic [ROUTE_W-1:0] route_t;

  function automatic logic route_on(route_t r, int unsigned n_lines);
    return int'(r) < int'(n_lines);
  endfunction
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_router_pkg::*;
#(
  parameter int unsigned N_PIRQ   = 4,
  parameter int unsigned CFG_BASE = 8'h60,
  parameter int unsigned DW_W     = 6,
  parameter int unsigned DATA_W   = 32,
  parameter route_t      RST_VAL  = 8'h80
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [DW_W-1:0]           dw_addr_i,
  input  logic [DATA_W/8-1:0]       be_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  output route_t [N_PIRQ-1:0]       route_q_o,
  output route_t [N_PIRQ-1:0]       route_d_o,
  output logic                      route_chg_o
);
  localparam int unsigned LANES = DATA_W / 8;

  logic [N_PIRQ-1:0] hit;
  route_t [N_PIRQ-1:0] route_q;

  for (genvar p = 0; p < N_PIRQ; p++) begin : g_reg
    localparam int unsigned BYTE_A = CFG_BASE + p;
    localparam int unsigned DW_A   = BYTE_A / LANES;
    localparam int unsigned LANE   = BYTE_A % LANES;

    assign hit[p] = wr_en_i && (dw_addr_i == DW_W'(DW_A)) && be_i[LANE];
    assign route_d_o[p] = hit[p] ? wdata_i[LANE*8 +: 8] : route_q[p];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) route_q[p] <= RST_VAL;
      else         route_q[p] <= route_d_o[p];
    end

    assert_hold_route_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hit[p] |=> $stable(route_q[p]));
  end

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < N_PIRQ; p++) begin
      if (dw_addr_i == DW_W'((CFG_BASE + p) / LANES))
        rdata_o[((CFG_BASE + p) % LANES)*8 +: 8] = route_q[p];
    end
  end

  assign route_q_o   = route_q;
  assign route_chg_o = |hit;
endmodule

// File: rtl/pirq_level_matrix.sv
module pirq_level_matrix
  import pirq_router_pkg::*;
#(
  parameter int unsigned N_PIRQ  = 4,
  parameter int unsigned N_LINES = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  route_t [N_PIRQ-1:0]  route_q_i,
  input  route_t [N_PIRQ-1:0]  route_d_i,
  input  logic                 rebuild_i,
  input  logic [N_PIRQ-1:0]    pirq_i,
  output logic [N_LINES-1:0]   lines_o
);
  localparam int unsigned MW    = N_PIRQ * N_LINES;
  localparam int unsigned IDX_W = $clog2(MW);

  logic [MW-1:0] m_q, m_d;

  // rebuild uses new routes; otherwise each pirq rewrites only its own bit
  always_comb begin
    m_d = m_q;
    if (rebuild_i) begin
      m_d = '0;
      for (int p = 0; p < N_PIRQ; p++)
        if (route_on(route_d_i[p], N_LINES))
          m_d[IDX_W'(int'(route_d_i[p]) * N_PIRQ + p)] = pirq_i[p];
    end else begin
      for (int p = 0; p < N_PIRQ; p++)
        if (route_on(route_q_i[p], N_LINES))
          m_d[IDX_W'(int'(route_q_i[p]) * N_PIRQ + p)] = pirq_i[p];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m_q <= '0;
    else         m_q <= m_d;
  end

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    assign lines_o[l] = |m_q[l*N_PIRQ +: N_PIRQ];
  end

  for (genvar p = 0; p < N_PIRQ; p++) begin : g_col
    logic [N_LINES-1:0] col;
    for (genvar l = 0; l < N_LINES; l++) begin : g_bit
      assign col[l] = m_q[l*N_PIRQ + p];
    end

    assert_single_line_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(col));
    assert_disabled_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !route_on(route_q_i[p], N_LINES) |-> (col == '0));
  end
endmodule

// File: rtl/pirq_slot_swizzle.sv
module pirq_slot_swizzle #(
  parameter int unsigned N_PIRQ = 4,
  parameter int unsigned SEL_W  = $clog2(N_PIRQ)
) (
  input  logic [7:0]       devfn_i,
  input  logic [SEL_W-1:0] intx_i,
  output logic [SEL_W-1:0] pirq_o
);
  logic [4:0] slot;
  logic [5:0] sum;
  logic       unused_bits;

  assign slot        = devfn_i[7:3];
  assign sum         = 6'(intx_i) + 6'(slot) + 6'(N_PIRQ - 1);
  assign pirq_o      = SEL_W'(sum % 6'(N_PIRQ));
  assign unused_bits = ^{devfn_i[2:0]};
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_router_pkg::*;
#(
  parameter int unsigned N_PIRQ   = 4,
  parameter int unsigned N_LINES  = 16,
  parameter int unsigned CFG_BASE = 8'h60,
  parameter int unsigned DW_W     = 6,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned SEL_W   = $clog2(N_PIRQ),
  localparam int unsigned LINE_W  = $clog2(N_LINES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [DW_W-1:0]     cfg_dw_addr_i,
  input  logic [DATA_W/8-1:0] cfg_be_i,
  input  logic [DATA_W-1:0]   cfg_wdata_i,
  output logic [DATA_W-1:0]   cfg_rdata_o,
  input  logic [N_PIRQ-1:0]   pirq_i,
  output logic [N_LINES-1:0]  irq_o,
  input  logic [SEL_W-1:0]    route_sel_i,
  output logic                route_en_o,
  output logic [LINE_W:0]     route_line_o,
  input  logic [7:0]          swz_devfn_i,
  input  logic [SEL_W-1:0]    swz_intx_i,
  output logic [SEL_W-1:0]    swz_pirq_o
);
  route_t [N_PIRQ-1:0] route_q, route_d;
  logic                route_chg;
  route_t              sel_route;

  pirq_route_regs #(
    .N_PIRQ(N_PIRQ), .CFG_BASE(CFG_BASE), .DW_W(DW_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(cfg_we_i), .dw_addr_i(cfg_dw_addr_i), .be_i(cfg_be_i),
    .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o),
    .route_q_o(route_q), .route_d_o(route_d), .route_chg_o(route_chg)
  );

  pirq_level_matrix #(.N_PIRQ(N_PIRQ), .N_LINES(N_LINES)) u_matrix (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .route_q_i(route_q), .route_d_i(route_d), .rebuild_i(route_chg),
    .pirq_i(pirq_i), .lines_o(irq_o)
  );

  pirq_slot_swizzle #(.N_PIRQ(N_PIRQ)) u_swz (
    .devfn_i(swz_devfn_i), .intx_i(swz_intx_i), .pirq_o(swz_pirq_o)
  );

  assign sel_route    = route_q[route_sel_i];
  assign route_en_o   = route_on(sel_route, N_LINES);
  assign route_line_o = route_en_o ? {1'b0, sel_route[LINE_W-1:0]} : '1;

  for (genvar p = 0; p < N_PIRQ; p++) begin : g_chk
    logic [LINE_W-1:0] line_idx;
    assign line_idx = route_q[p][LINE_W-1:0];

    assert_level_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!route_chg && route_on(route_q[p], N_LINES) && pirq_i[p]) |=> irq_o[line_idx]);
  end
endmodule

// File: tb/pirq_router_tb_top.sv
module pirq_router_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        we = 0;
  logic [5:0]  dw_addr = 6'h18;
  logic [3:0]  be = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [3:0]  pirq = 0;
  logic [15:0] irq;
  logic [1:0]  rsel = 0;
  logic        ren;
  logic [4:0]  rline;
  logic [7:0]  devfn = 0;
  logic [1:0]  intx = 0;
  logic [1:0]  spirq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pirq_router dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(we), .cfg_dw_addr_i(dw_addr), .cfg_be_i(be), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .pirq_i(pirq), .irq_o(irq),
    .route_sel_i(rsel), .route_en_o(ren), .route_line_o(rline),
    .swz_devfn_i(devfn), .swz_intx_i(intx), .swz_pirq_o(spirq)
  );

  typedef struct packed {
    logic [31:0] routes;
    logic [3:0]  lv;
    logic [15:0] exp;
  } vec_t;

  // routes byte0 = A .. byte3 = D; wired-OR, disable and rebuild cases
  localparam vec_t VECS [7] = '{
    '{32'h0F0A0503, 4'b1111, 16'h8428},
    '{32'h0F0A0503, 4'b0101, 16'h0408},
    '{32'h09090909, 4'b0010, 16'h0200},
    '{32'h09090909, 4'b1010, 16'h0200},
    '{32'h09090909, 4'b0000, 16'h0000},
    '{32'hFF800010, 4'b1111, 16'h0001},
    '{32'h20010E0E, 4'b0011, 16'h4000}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(logic [5:0] a, logic [3:0] b, logic [31:0] d, logic [3:0] lv);
    @(negedge clk);
    we = 1; dw_addr = a; be = b; wdata = d; pirq = lv;
    @(negedge clk);
    we = 0; be = 0;
  endtask

  task automatic cfg_rd(logic [5:0] a, output logic [31:0] d);
    dw_addr = a;
    #1 d = rdata;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (2) @(negedge clk);
    // R1 reset state
    cfg_rd(6'h18, rd);
    chk("R1 routes", rd, 32'h80808080);
    chk("R1 irq", 32'(irq), 32'h0);
    rsel = 2'd0; #1;
    chk("R8 reset query", {26'b0, ren, rline}, {26'b0, 1'b0, 5'h1F});
    rst_n = 1;
    @(negedge clk);

    // R3/R4/R7 table: routes and levels change in one cycle
    for (int i = 0; i < 7; i++) begin
      cfg_wr(6'h18, 4'hF, VECS[i].routes, VECS[i].lv);
      chk($sformatf("R3/R7 vec%0d", i), 32'(irq), 32'(VECS[i].exp));
    end

    // R2 partial byte enable: only lane 1 (pirq B) changes
    cfg_wr(6'h18, 4'b0010, 32'hAAAA07AA, 4'b0000);
    cfg_rd(6'h18, rd);
    chk("R2 lane write", rd, 32'h2001070E);
    // R2 other dword: no effect, reads zero
    cfg_wr(6'h19, 4'hF, 32'h01010101, 4'b0000);
    cfg_rd(6'h18, rd);
    chk("R2 foreign write", rd, 32'h2001070E);
    cfg_rd(6'h19, rd);
    chk("R2 foreign read", rd, 32'h0);
    dw_addr = 6'h18;
    chk("R2 irq quiet", 32'(irq), 32'h0);

    // R5 one-clock latency: B -> line 7
    @(negedge clk);
    pirq = 4'b0010;
    #4;
    chk("R5 before edge", 32'(irq), 32'h0);
    @(negedge clk);
    chk("R5 after edge", 32'(irq), 32'h0080);

    // R6 reroute B to 3 with level held: line 7 released
    cfg_wr(6'h18, 4'b0010, 32'h00000300, 4'b0010);
    chk("R6 reroute", 32'(irq), 32'h0008);

    // R7 route A to 5 while A rises and B falls
    cfg_wr(6'h18, 4'b0001, 32'h00000005, 4'b0001);
    chk("R7 same cycle", 32'(irq), 32'h0020);

    // R4 disable A while high
    cfg_wr(6'h18, 4'b0001, 32'h00000010, 4'b0001);
    chk("R4 disable", 32'(irq), 32'h0);
    pirq = 4'b1111;
    repeat (2) @(negedge clk);
    chk("R4 D off, C->1 B->3", 32'(irq), 32'h000A);

    // R8 route query, routes = 0x20010310
    rsel = 2'd1; #1;
    chk("R8 B", {26'b0, ren, rline}, {26'b0, 1'b1, 5'd3});
    rsel = 2'd0; #1;
    chk("R8 A off", {26'b0, ren, rline}, {26'b0, 1'b0, 5'h1F});
    rsel = 2'd2; #1;
    chk("R8 C", {26'b0, ren, rline}, {26'b0, 1'b1, 5'd1});
    rsel = 2'd3; #1;
    chk("R8 D off", {26'b0, ren, rline}, {26'b0, 1'b0, 5'h1F});

    // R9 swizzle
    devfn = 8'h08; intx = 2'd2; #1; chk("R9 slot1", 32'(spirq), 32'd2);
    devfn = 8'h10; intx = 2'd3; #1; chk("R9 slot2", 32'(spirq), 32'd0);
    devfn = 8'h00; intx = 2'd0; #1; chk("R9 slot0", 32'(spirq), 32'd3);
    devfn = 8'h2F; intx = 2'd1; #1; chk("R9 slot5", 32'(spirq), 32'd1);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 0;
    #1;
    cfg_rd(6'h18, rd);
    chk("R1 re-reset routes", rd, 32'h80808080);
    chk("R1 re-reset irq", 32'(irq), 32'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule